// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns a single PWM command into the high-side and low-side gate enables of a synchronous buck half-bridge. The command arrives as two comparator flags, so the input can sit high, low, or in a middle window. A window that persists for a programmable number of cycles parks both gates off.

Dead time adapts to the gates. It is not a fixed count. Each enable waits until a sense flag reports that the opposite gate has discharged below its turn-off threshold.

When forced-continuous operation is not requested, the low side runs as an emulated diode. It is released when the inductor current crosses zero, but never before a minimum on-time has elapsed. A watchdog counter flags a dead-time wait that never completes, and the waiting gate stays off.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: Out of reset, and in every cycle after one in which `pwr_ok` was sampled low, both enables are low and `shutdown` is high.
- R2: The level is decoded from the flags as follows. `pwm_hi_cmp`=1 with `pwm_lo_cmp`=0 is a high command. `pwm_lo_cmp`=1 with `pwm_hi_cmp`=0 is a low command. Both flags 0, or both flags 1, is the shutdown window. A window cycle carries the last valid command forward.
- R3: A high command removes `ls_en` at the next edge. `hs_en` rises one cycle after `lg_discharged` is sampled high while waiting, and not before.
- R4: A low command removes `hs_en` at the next edge. `ls_en` rises one cycle after `hg_discharged` is sampled high while waiting, and not before.
- R5: `hs_en` and `ls_en` are never high in the same cycle.
- R6: When the window is sampled for `HOLDOFF_CYC` consecutive cycles, `shutdown` rises and both enables fall at that edge, and they stay so while the window lasts. A shorter excursion has no effect on the enables.
- R7: `shutdown` clears one edge after a high or low command is sampled. The gate for that command then follows the dead-time rule of R3 or R4.
- R8: With `force_ccm`=0, `zero_cross` sampled during a low-side on period removes `ls_en` at the next edge. `ls_en` stays off until the next high command.
- R9: In emulation mode, `ls_en` stays high for at least `MIN_ON_CYC` cycles. If `zero_cross` is held from the first on cycle, the on period lasts exactly `MIN_ON_CYC` cycles.
- R10: With `force_ccm`=1, `zero_cross` has no effect on `ls_en`. Raising `force_ccm` while the low side is released restores `ls_en` two cycles later, provided `hg_discharged` is high.
- R11: When a dead-time wait has lasted `WAIT_LIMIT` cycles without its flag, `dt_fault` is high from the next cycle on, and both enables stay low. `dt_fault` clears when the wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good flag; low forces shutdown |
| pwm_hi_cmp | input | 1 | PWM above upper threshold |
| pwm_lo_cmp | input | 1 | PWM below lower threshold |
| lg_discharged | input | 1 | Low-side gate sensed below 1 V |
| hg_discharged | input | 1 | High-side gate-source sensed below 1 V |
| zero_cross | input | 1 | Inductor current zero-crossing detected |
| force_ccm | input | 1 | 1 forces continuous conduction; 0 allows diode emulation |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| shutdown | output | 1 | Both gates parked by window, reset or supply |
| dt_fault | output | 1 | Dead-time wait exceeded its limit |

## Verification
The hardest cases to reach are the exact boundaries of the two counted windows. The first is the shutdown holdoff, where one cycle short of the limit must leave the gates untouched. The second is the minimum low-side on-time under a zero-crossing that is already present when the low side turns on.

The stimulus holds the window for exactly `HOLDOFF_CYC-1` cycles, then for `HOLDOFF_CYC` cycles using the illegal both-flags code. It also asserts `zero_cross` in the first low-side cycle and measures the on period. A behavioural model, compared on every clock, covers the transitions in between: aborted waits, the return from release when `force_ccm` rises, and the timeout.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_HI  = 2'd1,
        LVL_WIN = 2'd2
    } pwm_lvl_t;

    typedef enum logic [2:0] {
        ST_PARK    = 3'd0,
        ST_WAIT_HS = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_WAIT_LS = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_LS_REL  = 3'd5
    } seq_st_t;

    // Illegal both-high code is folded into the window.
    function automatic pwm_lvl_t decode_lvl(input logic above, input logic below);
        if (above && !below)      return LVL_HI;
        else if (below && !above) return LVL_LO;
        else                      return LVL_WIN;
    endfunction

    function automatic logic is_wait(input seq_st_t s);
        return (s == ST_WAIT_HS) || (s == ST_WAIT_LS);
    endfunction

endpackage

// File: rtl/hbseq_span_timer.sv
module hbseq_span_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic reached
);
    localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q == LIM);
endmodule

// File: rtl/hbseq_level_decode.sv
module hbseq_level_decode
    import hbseq_pkg::*;
#(
    parameter int HOLDOFF_CYC = 40
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     above,
    input  logic     below,
    output pwm_lvl_t lvl,
    output logic     win_expired
);
    logic in_win;
    logic held_long;

    assign lvl    = decode_lvl(above, below);
    assign in_win = (lvl == LVL_WIN);

    // Counts window cycles already seen; saturates at HOLDOFF_CYC-1.
    hbseq_span_timer #(.LIMIT(HOLDOFF_CYC - 1)) hold_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     (in_win),
        .reached (held_long)
    );

    assign win_expired = in_win && held_long;
endmodule

// File: rtl/halfbridge_gate_seq.sv
module halfbridge_gate_seq
    import hbseq_pkg::*;
#(
    parameter int HOLDOFF_CYC = 40,
    parameter int MIN_ON_CYC  = 100,
    parameter int WAIT_LIMIT  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic pwm_hi_cmp,
    input  logic pwm_lo_cmp,
    input  logic lg_discharged,
    input  logic hg_discharged,
    input  logic zero_cross,
    input  logic force_ccm,
    output logic hs_en,
    output logic ls_en,
    output logic shutdown,
    output logic dt_fault
);
    pwm_lvl_t lvl;
    logic     win_expired;
    seq_st_t  st_q, st_d;
    logic     cmd_q, cmd;
    logic     min_done;
    logic     wait_hold;

    hbseq_level_decode #(.HOLDOFF_CYC(HOLDOFF_CYC)) dec_i (
        .clk         (clk),
        .rst         (rst),
        .above       (pwm_hi_cmp),
        .below       (pwm_lo_cmp),
        .lvl         (lvl),
        .win_expired (win_expired)
    );

    // Effective command: a window cycle keeps the last valid level.
    always_comb begin
        case (lvl)
            LVL_HI:  cmd = 1'b1;
            LVL_LO:  cmd = 1'b0;
            default: cmd = cmd_q;
        endcase
    end

    // Low-side on-time counter (restarts each on period).
    hbseq_span_timer #(.LIMIT(MIN_ON_CYC - 1)) on_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q == ST_LS_ON),
        .reached (min_done)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_PARK: begin
                if (lvl == LVL_HI)      st_d = ST_WAIT_HS;
                else if (lvl == LVL_LO) st_d = ST_WAIT_LS;
            end
            ST_WAIT_HS: begin
                if (!cmd)               st_d = ST_WAIT_LS;
                else if (lg_discharged) st_d = ST_HS_ON;
            end
            ST_HS_ON: begin
                if (!cmd)               st_d = ST_WAIT_LS;
            end
            ST_WAIT_LS: begin
                if (cmd)                st_d = ST_WAIT_HS;
                else if (hg_discharged) st_d = ST_LS_ON;
            end
            ST_LS_ON: begin
                if (cmd)                st_d = ST_WAIT_HS;
                else if (!force_ccm && zero_cross && min_done)
                                        st_d = ST_LS_REL;
            end
            ST_LS_REL: begin
                if (cmd)                st_d = ST_WAIT_HS;
                else if (force_ccm)     st_d = ST_WAIT_LS;
            end
            default:                    st_d = ST_PARK;
        endcase
        if (win_expired) st_d = ST_PARK;
        if (!pwr_ok)     st_d = ST_PARK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_PARK;
            cmd_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cmd_q <= cmd;
        end
    end

    assign wait_hold = is_wait(st_q) && (st_d == st_q);

    generate
        if (WAIT_LIMIT > 0) begin : g_wait_guard
            logic wait_over;
            hbseq_span_timer #(.LIMIT(WAIT_LIMIT)) wait_tmr_i (
                .clk     (clk),
                .rst     (rst),
                .run     (wait_hold),
                .reached (wait_over)
            );
            assign dt_fault = is_wait(st_q) && wait_over;
        end else begin : g_no_wait_guard
            assign dt_fault = 1'b0;
        end
    endgenerate

    assign hs_en    = (st_q == ST_HS_ON);
    assign ls_en    = (st_q == ST_LS_ON);
    assign shutdown = (st_q == ST_PARK);
endmodule

// File: rtl/hbseq_checker.sv
module hbseq_checker (
    input logic clk,
    input logic rst,
    input logic pwr_ok,
    input logic pwm_hi_cmp,
    input logic pwm_lo_cmp,
    input logic lg_discharged,
    input logic hg_discharged,
    input logic force_ccm,
    input logic hs_en,
    input logic ls_en,
    input logic shutdown
);
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_supply_parks_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (!hs_en && !ls_en && shutdown));

    assert_hs_waits_flag_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(lg_discharged));

    assert_ls_waits_flag_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(hg_discharged));

    assert_park_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(!pwr_ok || (pwm_hi_cmp == pwm_lo_cmp)));

    assert_ccm_keeps_ls_R10: assert property (@(posedge clk) disable iff (rst)
        (ls_en && force_ccm && pwr_ok && pwm_lo_cmp && !pwm_hi_cmp) |=> ls_en);
endmodule

bind halfbridge_gate_seq hbseq_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .pwr_ok        (pwr_ok),
    .pwm_hi_cmp    (pwm_hi_cmp),
    .pwm_lo_cmp    (pwm_lo_cmp),
    .lg_discharged (lg_discharged),
    .hg_discharged (hg_discharged),
    .force_ccm     (force_ccm),
    .hs_en         (hs_en),
    .ls_en         (ls_en),
    .shutdown      (shutdown)
);

// File: tb/halfbridge_gate_seq_tb_top.sv
module halfbridge_gate_seq_tb_top;
    localparam int HOLD  = 40;
    localparam int MINON = 100;
    localparam int WLIM  = 64;

    logic clk = 1'b0;
    logic rst, pwr_ok, hi, lo, lgd, hgd, zc, ccm;
    logic hs, ls, sd, flt;

    always #2 clk = ~clk;

    halfbridge_gate_seq #(.HOLDOFF_CYC(HOLD), .MIN_ON_CYC(MINON), .WAIT_LIMIT(WLIM)) dut_i (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pwm_hi_cmp(hi), .pwm_lo_cmp(lo),
        .lg_discharged(lgd), .hg_discharged(hgd), .zero_cross(zc), .force_ccm(ccm),
        .hs_en(hs), .ls_en(ls), .shutdown(sd), .dt_fault(flt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_en = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 park, 1 wait-high, 2 high on, 3 wait-low, 4 low on, 5 released
    int m_st = 0, m_tri = 0, m_on = 0, m_wait = 0;
    bit m_cmd = 0;

    always @(posedge clk) begin
        int lvl, nxt;
        bit cm, expd, mind;
        cyc++;
        cmp_en = 1;
        if (rst) begin
            m_st = 0; m_tri = 0; m_on = 0; m_wait = 0; m_cmd = 0;
        end else begin
            lvl  = (hi && !lo) ? 1 : ((lo && !hi) ? 0 : 2);
            cm   = (lvl == 1) ? 1'b1 : ((lvl == 0) ? 1'b0 : m_cmd);
            expd = (lvl == 2) && (m_tri == HOLD - 1);
            mind = (m_on == MINON - 1);
            nxt  = m_st;
            if (m_st == 0) nxt = (lvl == 1) ? 1 : ((lvl == 0) ? 3 : 0);
            else if (cm && m_st >= 3) nxt = 1;
            else if (!cm && m_st <= 2) nxt = 3;
            else if (m_st == 1 && lgd) nxt = 2;
            else if (m_st == 3 && hgd) nxt = 4;
            else if (m_st == 4 && !ccm && zc && mind) nxt = 5;
            else if (m_st == 5 && ccm) nxt = 3;
            if (expd || !pwr_ok) nxt = 0;
            m_tri  = (lvl == 2) ? ((m_tri < HOLD - 1) ? m_tri + 1 : m_tri) : 0;
            m_on   = (m_st == 4) ? ((m_on < MINON - 1) ? m_on + 1 : m_on) : 0;
            m_wait = ((m_st == 1 || m_st == 3) && nxt == m_st)
                     ? ((m_wait < WLIM) ? m_wait + 1 : m_wait) : 0;
            m_cmd  = cm;
            m_st   = nxt;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R3 hs_en vs model", hs, m_st == 2);
            chk("R4 ls_en vs model", ls, m_st == 4);
            chk("R6 shutdown vs model", sd, m_st == 0);
            chk("R11 dt_fault vs model", flt, (m_st == 1 || m_st == 3) && m_wait == WLIM);
            chk("R5 exclusive enables", hs && ls, 1'b0);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_high();
        hi = 1; lo = 0; lgd = 1; hgd = 0;
        for (int i = 0; i < 20 && !hs; i++) tick(1);
    endtask

    task automatic go_low();
        hi = 0; lo = 1; hgd = 1; lgd = 0;
        for (int i = 0; i < 20 && !ls; i++) tick(1);
    endtask

    initial begin
        int cnt;
        rst = 1; pwr_ok = 0; hi = 0; lo = 0; lgd = 0; hgd = 0; zc = 0; ccm = 1;
        tick(3);
        chk("R1 reset hs", hs, 0); chk("R1 reset ls", ls, 0); chk("R1 reset shutdown", sd, 1);
        rst = 0; hi = 1;
        tick(4);
        chk("R1 pwr_ok low keeps park", sd, 1);

        // R7 / R3: leave park on a high command, wait for low gate discharge
        pwr_ok = 1; lgd = 0; hgd = 1;
        tick(1);
        chk("R7 park cleared", sd, 0); chk("R7 hs waits", hs, 0);
        tick(5);
        chk("R3 hs held without flag", hs, 0);
        lgd = 1;
        tick(1);
        chk("R3 hs on after flag", hs, 1);

        // R4: falling command
        hi = 0; lo = 1; hgd = 0;
        tick(1);
        chk("R4 hs removed", hs, 0); chk("R4 ls waits", ls, 0);
        tick(3);
        chk("R4 ls held without flag", ls, 0);
        hgd = 1; lgd = 0;
        tick(1);
        chk("R4 ls on after flag", ls, 1);

        // R9: early zero crossing ignored
        ccm = 0;
        go_high(); go_low();
        zc = 1; tick(1); zc = 0; tick(1);
        chk("R9 early zero-cross ignored", ls, 1);

        // R9 / R8: measure on time with zero crossing present from start
        go_high(); go_low();
        zc = 1; cnt = 1;
        for (int i = 0; i < 400; i++) begin
            tick(1);
            if (ls) cnt++; else break;
        end
        chk("R9 on period equals minimum", cnt == MINON, 1);
        zc = 0;
        tick(5);
        chk("R8 released low stays off", ls, 0);

        // R10: forcing continuous mode restores the low side
        ccm = 1;
        tick(1);
        chk("R10 restore wait cycle", ls, 0);
        tick(1);
        chk("R10 low side restored", ls, 1);
        zc = 1; tick(150);
        chk("R10 zero-cross ignored in ccm", ls, 1);
        zc = 0;

        // R6 / R2: short window, then the illegal code for the full holdoff
        hi = 0; lo = 0;
        tick(HOLD - 1);
        chk("R6 short window no park", sd, 0); chk("R6 short window ls kept", ls, 1);
        lo = 1; tick(2);
        chk("R6 back to low", sd, 0);
        hi = 1; lo = 1;
        tick(HOLD - 1);
        chk("R2 illegal code counts as window", sd, 0);
        tick(1);
        chk("R6 parked after holdoff", sd, 1); chk("R6 ls off", ls, 0); chk("R6 hs off", hs, 0);
        tick(10);
        chk("R6 park held", sd, 1);

        // R7: leave window on a high command
        hi = 1; lo = 0; lgd = 0;
        tick(1);
        chk("R7 park cleared on high", sd, 0); chk("R7 hs waits for flag", hs, 0);
        lgd = 1;
        tick(1);
        chk("R7 hs after flag", hs, 1);

        // R11: timeout with high gate never reported discharged
        hi = 0; lo = 1; hgd = 0; lgd = 0;
        tick(WLIM);
        chk("R11 no fault at limit", flt, 0);
        tick(1);
        chk("R11 fault raised", flt, 1); chk("R11 ls stays off", ls, 0); chk("R11 hs off", hs, 0);
        hgd = 1;
        tick(1);
        chk("R11 fault cleared", flt, 0); chk("R11 ls after late flag", ls, 1);

        // R1: supply loss
        pwr_ok = 0;
        tick(1);
        chk("R1 supply loss parks", sd, 1); chk("R1 supply loss ls", ls, 0);
        tick(2);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule